// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a serial-in, serial-out delay line whose active length can be set to any value from one stage up to the full depth of its storage. A six-bit binary length code sets the length, and the length is the code value plus one. A select line picks one of two serial data inputs for the first stage. Tying the output back to the second input lets a loaded word recirculate without loss.

The register advances on either of two trigger conditions. The first is a rising edge on step pin 0 while step pin 1 is low. The second is a falling edge on step pin 1 while step pin 0 is high. Both step pins are asynchronous to the block. They pass through two-flop synchronizers on the system clock and are edge-detected there, so a qualifying pin change causes a shift on the third rising system-clock edge after it.

An active-high master clear empties every stage at once. It does not wait for a clock, and it overrides all other inputs. The block drives a true output and its complement.

Top module: `var_len_shreg`

## Requirements
- R1: With length code `len_i = c` (0 to 63), the active length is c+1 stages. A bit shifted in appears on `dout_o` after exactly c+1 shifts, and `dout_o` is 0 after a clear until that many shifts have happened.
- R2: While `rst_ni` is low, `dout_o` is 0 and `dout_n_o` is 1.
- R3: When `pick_a_i` is 1, each shift loads `din_a_i` into the first stage. When `pick_a_i` is 0, each shift loads `din_b_i`.
- R4: A 0-to-1 change of `step0_i` while `step1_i` is 0 causes one shift.
- R5: A 1-to-0 change of `step1_i` while `step0_i` is 1 causes one shift.
- R6: No other pin change causes a shift. This covers a rise of `step0_i` while `step1_i` is 1, a fall of `step1_i` while `step0_i` is 0, any fall of `step0_i` and any rise of `step1_i`.
- R7: If both trigger conditions arise in the same sampled cycle, exactly one shift is performed.
- R8: While `mclr_i` is 1, all stages are cleared at once, without a clock edge. `dout_o` is then 0 and `dout_n_o` is 1, and pin activity is ignored.
- R9: A change of `len_i` takes effect on `dout_o` at once and leaves the stored data unchanged.
- R10: `dout_n_o` is always the inverse of `dout_o`.
- R11: A qualifying step-pin change made between system-clock edges is reflected on `dout_o` after the third following rising edge of `clk_i`, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclr_i | input | 1 | Active-high asynchronous master clear of all stages |
| pick_a_i | input | 1 | 1 selects serial input A, 0 selects serial input B |
| din_a_i | input | 1 | Serial data input A |
| din_b_i | input | 1 | Serial data input B (recirculation path) |
| step0_i | input | 1 | Step pin 0, shifts on its rising edge while step1_i is low |
| step1_i | input | 1 | Step pin 1, shifts on its falling edge while step0_i is high |
| len_i | input | 6 | Length code, active length is len_i + 1 |
| dout_o | output | 1 | True output from the last active stage |
| dout_n_o | output | 1 | Complementary output |

## Verification
The bench builds the block with its default six-bit length code and 64-entry array. At that size every length from 1 to 64 can be swept exhaustively, and each sweep shifts a computed bit pattern through and compares the output after every shift. Because the sweep reaches the full depth, both the one-stage and the 64-stage extremes are covered, along with live length changes over a loaded word. Further directed sequences cover every pin transition in both gating states, the merged double trigger, recirculation through input B and the three-edge latency.

// File: rtl/vls_pkg.sv
package vls_pkg;
  parameter int unsigned LEN_W_DEF = 6;
  parameter int unsigned N_STEP    = 2;
  // step pin indices
  parameter int unsigned PIN_RISE  = 0;
  parameter int unsigned PIN_FALL  = 1;
endpackage

// File: rtl/vls_pin_sync.sv
module vls_pin_sync #(
  parameter int unsigned N_PINS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] lvl_o,
  output logic [N_PINS-1:0] rise_o,
  output logic [N_PINS-1:0] fall_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic ff1_q, ff2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q  <= 1'b0;
        ff2_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        ff1_q  <= pins_i[g];
        ff2_q  <= ff1_q;
        prev_q <= ff2_q;
      end
    end
    assign lvl_o[g]  = ff2_q;
    assign rise_o[g] = ff2_q & ~prev_q;
    assign fall_o[g] = ~ff2_q & prev_q;

    p_edge_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o[g] && fall_o[g]));
  end
endmodule

// File: rtl/vls_trig.sv
module vls_trig
  import vls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STEP-1:0] lvl_i,
  input  logic [N_STEP-1:0] rise_i,
  input  logic [N_STEP-1:0] fall_i,
  output logic              shift_o
);
  logic via_rise, via_fall;
  assign via_rise = rise_i[PIN_RISE] & ~lvl_i[PIN_FALL];
  assign via_fall = fall_i[PIN_FALL] &  lvl_i[PIN_RISE];
  // coincident conditions merge into a single shift
  assign shift_o  = via_rise | via_fall;

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i == '0 && fall_i == '0) |-> !shift_o);
  p_wrong_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i[PIN_RISE] && !fall_i[PIN_FALL]) |-> !shift_o);
endmodule

// File: rtl/vls_stages.sv
module vls_stages #(
  parameter int unsigned LEN_W = 6,
  localparam int unsigned DEPTH = 1 << LEN_W
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             shift_i,
  input  logic             din_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             tap_o
);
  logic [DEPTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)     stg_q <= '0;
    else if (shift_i) stg_q <= {stg_q[DEPTH-2:0], din_i};
  end

  // stages above the active length keep shifting, unobserved
  assign tap_o = stg_q[len_i];

  p_load_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
    shift_i |=> stg_q[0] == $past(din_i));
  p_move_r1: assert property (@(posedge clk_i) disable iff (!arst_ni)
    shift_i |=> stg_q[DEPTH-1:1] == $past(stg_q[DEPTH-2:0]));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !shift_i |=> $stable(stg_q));
endmodule

// File: rtl/var_len_shreg.sv
module var_len_shreg
  import vls_pkg::*;
#(
  parameter int unsigned LEN_W = LEN_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mclr_i,
  input  logic             pick_a_i,
  input  logic             din_a_i,
  input  logic             din_b_i,
  input  logic             step0_i,
  input  logic             step1_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             dout_o,
  output logic             dout_n_o
);
  logic [N_STEP-1:0] pins, lvl, rise, fall;
  logic shift, din_sel, tap, stg_rst_n;

  assign pins[PIN_RISE] = step0_i;
  assign pins[PIN_FALL] = step1_i;

  vls_pin_sync #(.N_PINS(N_STEP)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  vls_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rise_i (rise),
    .fall_i (fall),
    .shift_o(shift)
  );

  assign din_sel   = pick_a_i ? din_a_i : din_b_i;
  assign stg_rst_n = rst_ni & ~mclr_i;

  vls_stages #(.LEN_W(LEN_W)) u_stages (
    .clk_i  (clk_i),
    .arst_ni(stg_rst_n),
    .shift_i(shift),
    .din_i  (din_sel),
    .len_i  (len_i),
    .tap_o  (tap)
  );

  assign dout_o   = tap;
  assign dout_n_o = ~tap;

  p_clear_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |-> !dout_o);
  p_clear_comp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |-> dout_n_o);
endmodule

// File: tb/var_len_shreg_bench.sv
module var_len_shreg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 6;
  localparam int DEPTH = 1 << LW;

  logic clk = 0, rst_n = 0, mclr = 0, pick_a = 1, din_a = 0, din_b = 0;
  logic step0 = 0, step1 = 0;
  logic [LW-1:0] len = '0;
  logic dout, dout_n;
  int n_run = 0, n_fail = 0, n_sh = 0;
  logic hist [0:255];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  var_len_shreg #(.LEN_W(LW)) u_var_len_shreg (
    .clk_i(clk), .rst_ni(rst_n), .mclr_i(mclr), .pick_a_i(pick_a),
    .din_a_i(din_a), .din_b_i(din_b), .step0_i(step0), .step1_i(step1),
    .len_i(len), .dout_o(dout), .dout_n_o(dout_n)
  );

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (dout !== exp || dout_n !== ~exp) begin
      n_fail++;
      $display("FAIL %s: dout=%b dout_n=%b expected %b/%b", req, dout, dout_n, exp, ~exp);
    end
  endtask

  function automatic logic model(input int code);
    return (n_sh >= code + 1) ? hist[n_sh - code - 1] : 1'b0;
  endfunction

  task automatic pins(input logic a, input logic b);
    step0 = a; step1 = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear();
    mclr = 1; @(negedge clk); mclr = 0; @(negedge clk);
    n_sh = 0;
  endtask

  // shift via step0 rise (step1 low), pins end at 0/0
  task automatic shift_a(input logic b);
    pick_a = 1; din_a = b;
    pins(1, 0);
    hist[n_sh] = b; n_sh++;
    pins(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset", 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R1 R4 R10: exhaustive length sweep
    for (int c = 0; c < DEPTH; c++) begin
      len = c[LW-1:0];
      clear();
      chk("R1 empty after clear", 1'b0);
      for (int k = 0; k < c + 5; k++) begin
        shift_a(logic'(((k * 5 + c) >> 1) & 1) ^ logic'(k % 3 == 0));
        chk("R1 R4 sweep", model(c));
      end
    end

    // R5 R6 with length 1
    len = '0; clear(); pick_a = 1; din_a = 1;
    pins(0, 1); chk("R6 step1 rise", 1'b0);
    pins(1, 1); chk("R6 step0 rise with step1 high", 1'b0);
    pins(1, 0); chk("R5 step1 fall with step0 high", 1'b1);
    din_a = 0;
    pins(0, 0); chk("R6 step0 fall", 1'b1);
    pins(0, 1); chk("R6 step1 rise", 1'b1);
    pins(0, 0); chk("R6 step1 fall with step0 low", 1'b1);
    pins(1, 0); chk("R4 step0 rise", 1'b0);
    pins(0, 0);

    // R7: both conditions together, length 2
    len = 6'd1; clear();
    pins(0, 1);
    din_a = 1;
    pins(1, 0); chk("R7 single shift on coincident triggers", 1'b0);
    din_a = 0;
    pins(0, 0);
    pins(1, 0); chk("R7 second shift", 1'b1);
    pins(0, 0);

    // R3: input B
    len = '0; clear();
    pick_a = 0; din_a = 0; din_b = 1;
    pins(1, 0); pins(0, 0); chk("R3 input B selected", 1'b1);
    din_a = 1; din_b = 0;
    pins(1, 0); pins(0, 0); chk("R3 input B ignores A", 1'b0);

    // R3 recirculation, length 4
    len = 6'd3; clear();
    shift_a(1); shift_a(0); shift_a(1); shift_a(1);
    chk("R3 loaded", 1'b1);
    for (int k = 1; k <= 8; k++) begin
      pick_a = 0; din_b = dout;
      pins(1, 0); pins(0, 0);
      chk("R3 recirculate", hist[k % 4]);
    end

    // R9: live length change
    len = 6'd7; clear();
    for (int k = 0; k < 8; k++) shift_a(logic'(k == 1 || k == 4 || k == 5));
    for (int c = 0; c < 12; c++) begin
      len = c[LW-1:0]; #1;
      chk("R9 length change", model(c));
    end
    len = 6'd7; #1; chk("R9 data kept", model(7));

    // R8: asynchronous clear
    len = 6'd3; #1; chk("R8 precondition", 1'b1);
    @(negedge clk); #2 mclr = 1; #1;
    chk("R8 clear without clock", 1'b0);
    din_a = 1; pins(1, 0); pins(0, 0);
    chk("R8 pins ignored during clear", 1'b0);
    mclr = 0; n_sh = 0;
    for (int c = 0; c < DEPTH; c += 9) begin
      len = c[LW-1:0]; #1; chk("R8 all stages cleared", 1'b0);
    end
    len = 6'd63; #1; chk("R8 last stage cleared", 1'b0);

    // R11: latency, length 1
    len = '0; clear(); pick_a = 1; din_a = 1;
    step0 = 1;
    @(negedge clk); chk("R11 after edge 1", 1'b0);
    @(negedge clk); chk("R11 after edge 2", 1'b0);
    @(negedge clk); chk("R11 after edge 3", 1'b1);
    pins(0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule